// File: doc/BRIEF.md
# Row-to-Column Transpose Buffer

This block sits between the two passes of a block-edge filter. The first pass works along rows and the second along columns. The block holds one 4x4 tile of 8-bit pixels as four 32-bit row words. The first pass writes one row word per cycle. The second pass can then read back any whole column of four pixels in a single cycle, where four separate 32-bit reads would otherwise be needed. Reads can also return a stored row unchanged.

The read port is combinational. In the same cycle it returns either the row word at the given index, or the column gathered from all four rows at that index. A read that hits the word being written in the same cycle sees the new data. Each row has a presence bit. A pulse at the start of a new tile clears all presence bits, and the read port reports whether the returned word is made only of rows written for the current tile.

Top module: `xpose_buf`

## Requirements
- R1: While reset is asserted and after it is released, all stored words read as zero and every read reports not valid.
- R2: A row word written in one cycle is returned by a row-mode read of that row in any later cycle until it is overwritten or reset.
- R3: In every word, byte lane k (bits 8k+7:8k, lane 0 least significant) carries the pixel of column k for row words and of row k for column words.
- R4: In column mode with index c, output lane r equals lane c of stored row r, for all four rows.
- R5: A row-mode read of the row being written in the same cycle returns the incoming write word.
- R6: A column-mode read in the cycle of a write takes the written row's lane from the incoming word and the other lanes from storage.
- R7: A row-mode read reports valid exactly when that row was written since the last tile-start pulse, counting a write in the same cycle.
- R8: A column-mode read reports valid only when all four rows are present, counting a write in the same cycle.
- R9: A tile-start pulse clears every presence bit, and stored data is kept. A write in the same cycle as the pulse counts as the first row of the new tile, and no row written before the pulse counts as present during it.
- R10: When the write enable is low, stored words and presence bits do not change, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_start | input | 1 | One-cycle pulse that begins a new tile |
| wr_en | input | 1 | Row write enable |
| wr_row | input | 2 | Row index of the write |
| wr_word | input | 32 | Row word, lane k = column k |
| rd_col_mode | input | 1 | 1 = column read, 0 = row read |
| rd_idx | input | 2 | Row or column index of the read |
| rd_word | output | 32 | Read word |
| rd_valid | output | 1 | Read word is made entirely of rows of the current tile |

## Verification
A read can fall in the same cycle as a write or as a tile-start pulse. This is where the forwarding path and the presence logic meet. The stimulus table includes writes to the row being read. It includes column reads while the last missing row is still being written, and a tile-start pulse together with a write while a column is read. For each such cycle the expected word is assembled lane by lane from rows known to be in storage and the incoming word, and the expected valid flag comes from the rows written since the pulse.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  parameter int PIX_W  = 8;
  parameter int DIM    = 4;
  localparam int WORD_W = PIX_W * DIM;
  localparam int IDX_W  = $clog2(DIM);

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [WORD_W-1:0] word_t;

  // Pixel at byte lane k of a word, lane 0 least significant.
  function automatic pix_t lane_of(input word_t w, input logic [IDX_W-1:0] k);
    return w[k*PIX_W +: PIX_W];
  endfunction

  // Hit test for a write against a given row.
  function automatic logic row_hit(input logic en, input logic [IDX_W-1:0] wrow,
                                   input logic [IDX_W-1:0] row);
    return en && (wrow == row);
  endfunction
endpackage

// File: rtl/xpose_row_store.sv
module xpose_row_store
  import xpose_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_row,
  input  logic [WORD_W-1:0]     wr_word,
  output logic [DIM*WORD_W-1:0] rows_flat,
  output logic [DIM-1:0]        row_vld
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic [WORD_W-1:0] word_q;
    logic              vld_q;
    logic              hit;

    assign hit = row_hit(wr_en, wr_row, IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (hit) word_q <= wr_word;
        if (hit)      vld_q <= 1'b1;
        else if (clr) vld_q <= 1'b0;
      end
    end

    assign rows_flat[r*WORD_W +: WORD_W] = word_q;
    assign row_vld[r] = vld_q;
  end
endmodule

// File: rtl/xpose_read_mux.sv
module xpose_read_mux
  import xpose_pkg::*;
(
  input  logic [DIM*WORD_W-1:0] rows_flat,
  input  logic [DIM-1:0]        row_vld,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_row,
  input  logic [WORD_W-1:0]     wr_word,
  input  logic                  col_mode,
  input  logic [IDX_W-1:0]      idx,
  output logic [WORD_W-1:0]     rd_word,
  output logic                  rd_valid
);
  logic [WORD_W-1:0] row_eff [DIM];
  logic [DIM-1:0]    vld_eff;
  logic [WORD_W-1:0] col_word;

  for (genvar r = 0; r < DIM; r++) begin : g_fwd
    logic hit;
    assign hit        = row_hit(wr_en, wr_row, IDX_W'(r));
    assign row_eff[r] = hit ? wr_word : rows_flat[r*WORD_W +: WORD_W];
    assign vld_eff[r] = (row_vld[r] & ~clr) | hit;
    assign col_word[r*PIX_W +: PIX_W] = lane_of(row_eff[r], idx);
  end

  always_comb begin
    if (col_mode) begin
      rd_word  = col_word;
      rd_valid = &vld_eff;
    end else begin
      rd_word  = row_eff[idx];
      rd_valid = vld_eff[idx];
    end
  end
endmodule

// File: rtl/xpose_buf.sv
module xpose_buf
  import xpose_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tile_start,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_col_mode,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid
);
  // Named internal state, brought out for the checker.
  logic [DIM*WORD_W-1:0] store_flat;
  logic [DIM-1:0]        store_vld;

  xpose_row_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tile_start),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_word   (wr_word),
    .rows_flat (store_flat),
    .row_vld   (store_vld)
  );

  xpose_read_mux u_rd (
    .rows_flat (store_flat),
    .row_vld   (store_vld),
    .clr       (tile_start),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_word   (wr_word),
    .col_mode  (rd_col_mode),
    .idx       (rd_idx),
    .rd_word   (rd_word),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/xpose_buf_chk.sv
module xpose_buf_chk
  import xpose_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tile_start,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_row,
  input logic [WORD_W-1:0]     wr_word,
  input logic                  rd_col_mode,
  input logic [IDX_W-1:0]      rd_idx,
  input logic [WORD_W-1:0]     rd_word,
  input logic                  rd_valid,
  input logic [DIM*WORD_W-1:0] store_flat,
  input logic [DIM-1:0]        store_vld
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store_flat[$past(wr_row)*WORD_W +: WORD_W] == $past(wr_word)); // R2
  AST_ROW_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_col_mode && rd_idx == wr_row) |-> rd_word == wr_word); // R5
  AST_WRITE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store_vld[$past(wr_row)]); // R7
  AST_COL_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_col_mode && !wr_en && !tile_start) |-> rd_valid == (&store_vld)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_start && !wr_en) |=> store_vld == '0); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_flat)); // R10
endmodule

bind xpose_buf xpose_buf_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tile_start  (tile_start),
  .wr_en       (wr_en),
  .wr_row      (wr_row),
  .wr_word     (wr_word),
  .rd_col_mode (rd_col_mode),
  .rd_idx      (rd_idx),
  .rd_word     (rd_word),
  .rd_valid    (rd_valid),
  .store_flat  (store_flat),
  .store_vld   (store_vld)
);

// File: tb/tb_xpose_buf.sv
module tb_xpose_buf;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  typedef struct packed {
    logic        st;
    logic        we;
    logic [1:0]  wrow;
    logic [31:0] wdat;
    logic        cm;
    logic [1:0]  idx;
    logic [31:0] xd;
    logic        xv;
  } vec_t;

  // Row r holds bytes r*16+k in lane k; column c gathers r*16+c in lane r.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h00000000, 1'b0}, // R1 empty after reset
    '{1'b0, 1'b1, 2'd0, 32'h03020100, 1'b0, 2'd0, 32'h03020100, 1'b1}, // R5 row forward
    '{1'b0, 1'b1, 2'd1, 32'h13121110, 1'b1, 2'd2, 32'h00001202, 1'b0}, // R6 col forward, partial
    '{1'b0, 1'b1, 2'd2, 32'h23222120, 1'b0, 2'd0, 32'h03020100, 1'b1}, // R2 stored row
    '{1'b0, 1'b1, 2'd3, 32'h33323130, 1'b1, 2'd1, 32'h31211101, 1'b1}, // R8 last row in flight
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 2'd0, 32'h30201000, 1'b1}, // R4 column 0
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b1, 2'd3, 32'h33231303, 1'b1}, // R3 top lanes
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd2, 32'h23222120, 1'b1}, // R3 row lanes
    '{1'b1, 1'b1, 2'd1, 32'hAABBCCDD, 1'b1, 2'd0, 32'h3020DD00, 1'b0}, // R9 start with write
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd1, 32'hAABBCCDD, 1'b1}, // R7 present row
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h03020100, 1'b0}, // R9 data kept, absent
    '{1'b0, 1'b0, 2'd0, 32'hFFFFFFFF, 1'b0, 2'd0, 32'h03020100, 1'b0}, // R10 idle inputs
    '{1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 2'd0, 32'h03020100, 1'b0}  // R10 after edge
  };
  string tags [NV] = '{"R1","R5","R6","R2","R8","R4","R3","R3","R9","R7","R9","R10","R10"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tile_start = 1'b0, wr_en = 1'b0, rd_col_mode = 1'b0;
  logic [1:0]  wr_row = '0, rd_idx = '0;
  logic [31:0] wr_word = '0;
  logic [31:0] rd_word;
  logic        rd_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  xpose_buf dut (
    .clk(clk), .rst_n(rst_n), .tile_start(tile_start), .wr_en(wr_en),
    .wr_row(wr_row), .wr_word(wr_word), .rd_col_mode(rd_col_mode),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] xd, input logic xv);
    checks++;
    if (rd_word !== xd || rd_valid !== xv) begin
      fails++;
      $display("FAIL %s: got word=%h valid=%b, expected word=%h valid=%b",
               tag, rd_word, rd_valid, xd, xv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_idx = 2'd3; #1;
    check("R1", 32'h0, 1'b0);             // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tile_start  = VECS[i].st;
      wr_en       = VECS[i].we;
      wr_row      = VECS[i].wrow;
      wr_word     = VECS[i].wdat;
      rd_col_mode = VECS[i].cm;
      rd_idx      = VECS[i].idx;
      #2;
      check(tags[i], VECS[i].xd, VECS[i].xv);
    end
    // R1: reset in mid-run wipes data and presence
    @(negedge clk);
    tile_start = 1'b0; wr_en = 1'b0; rd_col_mode = 1'b0; rd_idx = 2'd1;
    rst_n = 1'b0; #2;
    check("R1", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; rd_col_mode = 1'b1; rd_idx = 2'd0; #2;
    check("R1", 32'h0, 1'b0);
    // R7: written row valid, unwritten row not
    @(negedge clk);
    wr_en = 1'b1; wr_row = 2'd2; wr_word = 32'h5A5A5A5A; rd_col_mode = 1'b0; rd_idx = 2'd3;
    #2; check("R7", 32'h0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0; rd_idx = 2'd2; #2;
    check("R7", 32'h5A5A5A5A, 1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P*2000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule